// File: doc/BRIEF.md
# Collision, Jabber and Heartbeat Controller

This block is the digital control core of a 10BASE-T attachment unit. It watches two qualified activity flags, one for data arriving from the host for transmission and one for data arriving on the twisted-pair receive pair. When both are active at the same time it reports a collision to the host as a 10 MHz square wave. It also keeps that wave running for a short, fixed stretch once the collision ends, and the length of the stretch depends on which side went quiet first.

The block runs on a 20 MHz clock, so one bit time is two cycles. A watchdog inhibits the transmitter when a transmission runs too long. While it is tripped it reports collision and lights an active-low jabber indicator. It releases only after a long run of idle on the transmit input. After each clean transmission, and when the heartbeat mode bit is set, it sends a short test burst on the collision output. Two further functions are small. A short blanking window after each frame hides transmit activity. A link-pulse request is passed to the line driver whatever the watchdog state. The long timers are parameters, so a simulation can shorten them.

Top module: `col_jab_ctrl`

## Requirements
- R1: When transmit activity (`tx_act`), receive activity (`rx_act`) and a good link (`link_fail` low) are all sampled at a clock edge, `col_out` is high after that edge, provided no collision signalling was active before it.
- R2: While collision presence is active, `col_out` inverts on every clock, which gives 10 MHz at a 20 MHz clock. It starts high and is never high on two consecutive cycles. It is low whenever presence is inactive.
- R3: While `link_fail` is high, simultaneous transmit and receive activity produces no collision signalling.
- R4: If receive activity ends while transmit activity continues, collision signalling stays active for RX_STR clock edges (default 14, i.e. 7 bit times). The count starts at the first edge that samples receive low.
- R5: If transmit activity ends first, or both end together, collision signalling stays active for TX_STR clock edges (default 16, i.e. 8 bit times). The count starts at the first edge that samples transmit low.
- R6: After JAB_LIMIT consecutive clock edges with transmit activity, `tx_inhibit` goes high and `jab_n` goes low at that edge. Collision signalling begins on the next edge.
- R7: Once jabbered, the block releases (`tx_inhibit` low, `jab_n` high) on the UNJAB_HOLD-th consecutive edge that samples `tx_act` low. Any transmit activity during the hold restarts that count.
- R8: With `hb_en` high, a transmission that ends without collision, jabber or link failure produces a heartbeat burst. The edge that first samples transmit low is edge F. `col_out` toggles on edges F+HB_DLY+1 through F+HB_DLY+HB_LEN (defaults 12 and 20), starting high, and is low afterwards.
- R9: No heartbeat burst follows a transmission when `hb_en` is low, or when the transmission saw a collision.
- R10: For BLANK clock edges after the edge that ends a transmission (default 10, i.e. 500 ns), `tx_act` is ignored, so it cannot raise a collision. On the next edge it counts again.
- R11: `lp_out` follows `lp_req` one clock later, and this holds while jabbered.
- R12: During reset, `col_out` and `tx_inhibit` are low, and `jab_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 20 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_act | input | 1 | Qualified transmit-input activity from the host side |
| rx_act | input | 1 | Qualified twisted-pair receive activity |
| link_fail | input | 1 | High while the link is in the failed state |
| hb_en | input | 1 | Heartbeat test enable mode bit |
| lp_req | input | 1 | Link-integrity pulse request from the link timer |
| col_out | output | 1 | Collision presence square wave toward the host |
| tx_inhibit | output | 1 | High while the watchdog holds the transmitter off |
| jab_n | output | 1 | Active-low jabber indicator |
| lp_out | output | 1 | Link pulse gate to the line driver |

## Verification
The assertions assume that every input is synchronous to the 20 MHz clock and already qualified, so a flag never glitches within a cycle. They also assume that `hb_en` does not change while a transmission is in progress. The directed stimulus changes inputs only on the falling clock edge and holds each one for whole cycles. Every frame is kept far shorter than the watchdog limit except the one that trips it. Each scenario ends with a long enough idle gap that the stretch, blanking and heartbeat timers have expired before the next one starts.

// File: rtl/col_jab_ctrl.sv
module col_jab_ctrl #(
  parameter int JAB_LIMIT  = 1_000_000,
  parameter int UNJAB_HOLD = 10_000_000,
  parameter int RX_STR     = 14,
  parameter int TX_STR     = 16,
  parameter int HB_DLY     = 12,
  parameter int HB_LEN     = 20,
  parameter int BLANK      = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act,
  input  logic rx_act,
  input  logic link_fail,
  input  logic hb_en,
  input  logic lp_req,
  output logic col_out,
  output logic tx_inhibit,
  output logic jab_n,
  output logic lp_out
);

  localparam int SMAX = (RX_STR > TX_STR) ? RX_STR : TX_STR;
  localparam int BW = $clog2(BLANK + 1);
  localparam int SW = $clog2(SMAX + 1);
  localparam int HW = $clog2(HB_DLY + HB_LEN + 1);
  localparam int JW = $clog2(JAB_LIMIT + 1);
  localparam int UW = $clog2(UNJAB_HOLD + 1);

  localparam logic [BW-1:0] BLANK_C = BW'(BLANK);
  localparam logic [SW-1:0] RX_LD   = SW'(RX_STR - 1);
  localparam logic [SW-1:0] TX_LD   = SW'(TX_STR - 1);
  localparam logic [HW-1:0] HB_LD   = HW'(HB_DLY + HB_LEN);
  localparam logic [HW-1:0] HB_LEN_C = HW'(HB_LEN);
  localparam logic [JW-1:0] JAB_TOP = JW'(JAB_LIMIT - 1);
  localparam logic [UW-1:0] UNJAB_C = UW'(UNJAB_HOLD);
  localparam logic [UW-1:0] UNJAB_1 = UW'(1);

  logic [BW-1:0] blank_cnt;
  logic [SW-1:0] str_cnt;
  logic [HW-1:0] hb_cnt;
  logic [JW-1:0] jab_cnt;
  logic [UW-1:0] unjab_cnt;
  logic tx_d, coll_d, fcol, jab;

  logic txv, coll, tx_end, hb_go, hb_on, col_req;

  assign txv     = tx_act && (blank_cnt == '0);
  assign coll    = txv && rx_act && !link_fail;
  assign tx_end  = tx_d && !txv;
  assign hb_go   = tx_end && hb_en && !jab && !link_fail && !fcol;
  assign hb_on   = (hb_cnt != '0) && (hb_cnt <= HB_LEN_C);
  assign col_req = ((coll || coll_d || (str_cnt != '0)) && !link_fail) || jab || hb_on;

  assign tx_inhibit = jab;
  assign jab_n      = !jab;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_d      <= 1'b0;
      coll_d    <= 1'b0;
      fcol      <= 1'b0;
      blank_cnt <= '0;
      str_cnt   <= '0;
      hb_cnt    <= '0;
      col_out   <= 1'b0;
      lp_out    <= 1'b0;
    end else begin
      tx_d    <= txv;
      coll_d  <= coll;
      fcol    <= txv ? (fcol || coll) : 1'b0;
      lp_out  <= lp_req;
      col_out <= col_req ? !col_out : 1'b0;

      if (tx_end)                blank_cnt <= BLANK_C;
      else if (blank_cnt != '0)  blank_cnt <= blank_cnt - BW'(1);

      if (coll)                        str_cnt <= '0;
      else if (coll_d && !link_fail)   str_cnt <= txv ? RX_LD : TX_LD;
      else if (str_cnt != '0)          str_cnt <= str_cnt - SW'(1);

      if (hb_go)               hb_cnt <= HB_LD;
      else if (hb_cnt != '0)   hb_cnt <= hb_cnt - HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      jab       <= 1'b0;
      jab_cnt   <= '0;
      unjab_cnt <= '0;
    end else if (jab) begin
      jab_cnt <= '0;
      if (tx_act) unjab_cnt <= UNJAB_C;
      else if (unjab_cnt == UNJAB_1) begin
        jab       <= 1'b0;
        unjab_cnt <= '0;
      end else unjab_cnt <= unjab_cnt - UW'(1);
    end else if (txv) begin
      if (jab_cnt == JAB_TOP) begin
        jab       <= 1'b1;
        unjab_cnt <= UNJAB_C;
      end else jab_cnt <= jab_cnt + JW'(1);
    end else jab_cnt <= '0;
  end

  p_col_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    coll |=> (col_out != $past(col_out)));

  p_wave_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_out |=> !col_out);

  p_linkfail_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fail && !jab && !hb_on) |=> !col_out);

  p_jab_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jab) |-> $past(tx_act));

  p_jab_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (jab && tx_act) |=> jab);

  p_hb_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!hb_en && hb_cnt == '0) |=> (hb_cnt == '0));

  p_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((blank_cnt != '0) && !jab) |=> (jab_cnt == '0));

  p_lp_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |=> lp_out);

endmodule

// File: tb/sim_col_jab_ctrl.sv
module sim_col_jab_ctrl;
  localparam int JL = 200;
  localparam int UH = 400;
  localparam int RS = 14;
  localparam int TS = 16;
  localparam int HD = 12;
  localparam int HL = 20;
  localparam int BL = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_act = 1'b0, rx_act = 1'b0, link_fail = 1'b0, hb_en = 1'b0, lp_req = 1'b0;
  logic col_out, tx_inhibit, jab_n, lp_out;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  col_jab_ctrl #(.JAB_LIMIT(JL), .UNJAB_HOLD(UH), .RX_STR(RS), .TX_STR(TS),
                 .HB_DLY(HD), .HB_LEN(HL), .BLANK(BL)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_act(tx_act), .rx_act(rx_act),
    .link_fail(link_fail), .hb_en(hb_en), .lp_req(lp_req),
    .col_out(col_out), .tx_inhibit(tx_inhibit), .jab_n(jab_n), .lp_out(lp_out));

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic quiet(input string req, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (col_out) seen = 1'b1;
    end
    chk(req, seen, 1'b0);
  endtask

  task automatic t_reset();
    tick(3);
    chk("R12 col_out", col_out, 1'b0);
    chk("R12 tx_inhibit", tx_inhibit, 1'b0);
    chk("R12 jab_n", jab_n, 1'b1);
    rst_n = 1'b1;
    tick(3);
  endtask

  task automatic t_rx_first();
    hb_en = 1'b0;
    tx_act = 1'b1; tick(3);
    rx_act = 1'b1; tick(1);
    chk("R1 start", col_out, 1'b1);
    tick(1); chk("R2 toggle low", col_out, 1'b0);
    tick(1); chk("R2 toggle high", col_out, 1'b1);
    tick(2); rx_act = 1'b0;
    tick(13); chk("R4 before last", col_out, 1'b0);
    tick(1);  chk("R4 last high", col_out, 1'b1);
    tick(1);  chk("R4 end", col_out, 1'b0);
    tick(1);  chk("R4 stays idle", col_out, 1'b0);
    tx_act = 1'b0; tick(40);
  endtask

  task automatic t_tx_first();
    hb_en = 1'b1;
    tx_act = 1'b1; tick(2);
    rx_act = 1'b1; tick(1);
    chk("R1 start tx-first", col_out, 1'b1);
    tick(2); tx_act = 1'b0;
    tick(15); chk("R5 before last", col_out, 1'b0);
    tick(1);  chk("R5 last high", col_out, 1'b1);
    tick(1);  chk("R5 end", col_out, 1'b0);
    tick(1);  chk("R5 stays idle", col_out, 1'b0);
    quiet("R9 no burst after collision", 16);
    rx_act = 1'b0; hb_en = 1'b0; tick(10);
  endtask

  task automatic t_link_fail();
    link_fail = 1'b1;
    tx_act = 1'b1; rx_act = 1'b1;
    quiet("R3 link fail", 8);
    tx_act = 1'b0; rx_act = 1'b0; tick(2);
    link_fail = 1'b0; tick(20);
  endtask

  task automatic t_heartbeat();
    hb_en = 1'b1;
    tx_act = 1'b1; tick(6);
    tx_act = 1'b0; tick(1);
    tick(HD);     chk("R8 before burst", col_out, 1'b0);
    tick(1);      chk("R8 burst first", col_out, 1'b1);
    tick(1);      chk("R8 burst toggles", col_out, 1'b0);
    tick(HL - 3); chk("R8 burst last high", col_out, 1'b1);
    tick(1);      chk("R8 burst end", col_out, 1'b0);
    tick(1);      chk("R8 idle after burst", col_out, 1'b0);
    hb_en = 1'b0; tick(10);
  endtask

  task automatic t_hb_disabled();
    hb_en = 1'b0;
    tx_act = 1'b1; tick(6);
    tx_act = 1'b0;
    quiet("R9 heartbeat disabled", HD + HL + 8);
  endtask

  task automatic t_blank();
    hb_en = 1'b0;
    tx_act = 1'b1; tick(5);
    tx_act = 1'b0; tick(1);
    tx_act = 1'b1; rx_act = 1'b1;
    quiet("R10 blanked activity", BL);
    tick(1); chk("R10 activity after blank", col_out, 1'b1);
    tx_act = 1'b0; rx_act = 1'b0; tick(40);
  endtask

  task automatic t_jabber();
    hb_en = 1'b0;
    tx_act = 1'b1;
    tick(JL - 1);
    chk("R6 not yet inhibited", tx_inhibit, 1'b0);
    chk("R6 indicator off", jab_n, 1'b1);
    tick(1);
    chk("R6 inhibit", tx_inhibit, 1'b1);
    chk("R6 indicator on", jab_n, 1'b0);
    tick(1); chk("R6 collision high", col_out, 1'b1);
    tick(1); chk("R6 collision toggles", col_out, 1'b0);
    lp_req = 1'b1; tick(1);
    chk("R11 link pulse while jabbered", lp_out, 1'b1);
    lp_req = 1'b0; tick(1);
    chk("R11 link pulse ends", lp_out, 1'b0);
  endtask

  task automatic t_unjab();
    tx_act = 1'b0; tick(100);
    tx_act = 1'b1; tick(3);
    tx_act = 1'b0;
    tick(UH - 1);
    chk("R7 hold restarted", tx_inhibit, 1'b1);
    tick(1);
    chk("R7 released", tx_inhibit, 1'b0);
    chk("R7 indicator off", jab_n, 1'b1);
    tick(10);
  endtask

  initial begin
    t_reset();
    t_rx_first();
    t_tx_first();
    t_link_fail();
    t_heartbeat();
    t_hb_disabled();
    t_blank();
    t_jabber();
    t_unjab();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule